// File: doc/BRIEF.md
# Low-Power Sleep Counter

This block is a 32-bit free-running timer that keeps time from one of two slow time bases. The slow clocks arrive as single-cycle strobes on the fast bus clock: `rc_tick` for the calibrated ~1 kHz source and `xtal_tick` for the 32 kHz source. The selected strobe passes through a power-of-two prescaler. The prescaler's roll-over steps the counter up or down, and the counter wraps at the ends of its range. The counter can freeze while the processor is halted for debug.

Software uses a small word-addressed register set.

| Address | Register |
|---|---|
| 0 | Configuration |
| 1 | High half of the count |
| 2 | Low half of the count |
| 3 | Reads as zero |

The enable bit reaches the timer side through a two-stage synchroniser that advances on the selected strobe. For this reason, starting and stopping the timer lag the register write by a few slow-clock periods. The source, prescaler and direction fields can only change while the timer is disabled.

Top module: `sleep_counter`

## Requirements
- R1: After reset the configuration reads 0x0000_0400 and the count reads 0. The configuration bits are: source select at bit 0, prescaler N at bits 7:4, debug-pause at bit 10, enable at bit 11 and direction at bit 12. Every other configuration bit reads 0. Address 1 reads the captured high half and address 2 reads the live low half, each in bits 15:0.
- R2: Source select 0 makes the timer advance only on `rc_tick`, and source select 1 makes it advance only on `xtal_tick`. Strobes on the unselected source have no effect.
- R3: With prescaler N, the counter takes one step for every 2^N selected strobes while running. The prescaler phase starts from zero each time the timer starts, so after T running strobes the count has moved floor(T/2^N).
- R4: Direction 0 steps the count up by one and direction 1 steps it down by one.
- R5: While the enable bit is 1, writes leave source select, prescaler and direction unchanged. Enable and debug-pause are written on every configuration write.
- R6: After the enable bit changes, the first two selected strobes still behave as under the old setting. From the third strobe onward the new setting applies.
- R7: When debug-pause is 1 and `cpu_halted` is high, selected strobes neither step the count nor advance the prescaler. When debug-pause is 0, `cpu_halted` has no effect.
- R8: The count wraps modulo 2^32: 0 steps down to 0xFFFF_FFFF, and 0xFFFF_FFFF steps up to 0.
- R9: A read of address 2 captures the high half of the count at that moment. Later reads of address 1 return that captured value, even if the count has changed since.
- R10: The count changes by at most one step per bus clock, and only on a cycle with a selected strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| rc_tick | input | 1 | One-cycle strobe from the ~1 kHz source |
| xtal_tick | input | 1 | One-cycle strobe from the 32 kHz source |
| cpu_halted | input | 1 | Processor halted in debug |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |

## Verification
Configuration writes and strobes take effect at the clock edge on which they are presented. Read data is combinational, and the high-half capture happens at the edge of the low-half read. The bench therefore drives every input on the falling edge and samples on the next falling edge, so each result has exactly one rising edge behind it. For the synchronised enable, the bench counts selected strobes rather than bus cycles. It reads the count after the second strobe and again after the third, so the boundary of the 2-strobe latency is checked on both sides.

// File: rtl/sleep_counter.sv
module sleep_counter #(
  parameter int CNT_W  = 32,
  parameter int NSEL_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rc_tick,
  input  logic        xtal_tick,
  input  logic        cpu_halted,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam int PRE_W = (1 << NSEL_W) - 1;
  localparam int HALF  = CNT_W / 2;

  logic              sel_q, dir_q, dbgp_q, en_q;
  logic [NSEL_W-1:0] div_q;
  logic              s1_q, run;
  logic [PRE_W-1:0]  pre_q, mask;
  logic [CNT_W-1:0]  cnt_q;
  logic [HALF-1:0]   hi_snap;
  logic              tick, hold, step, cnt_en, cfg_wr;
  logic [31:0]       cfg_img;
  logic              unused_bits;

  assign cfg_wr = wr_en && addr == 2'd0;
  assign tick   = sel_q ? xtal_tick : rc_tick;
  assign hold   = dbgp_q & cpu_halted;
  assign step   = tick & run & ~hold;
  assign mask   = ~({PRE_W{1'b1}} << div_q);
  assign cnt_en = step && ((pre_q & mask) == mask);
  assign unused_bits = ^{wdata[31:13], wdata[9:8], wdata[3:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      dir_q  <= 1'b0;
      div_q  <= '0;
      dbgp_q <= 1'b1;
      en_q   <= 1'b0;
    end else if (cfg_wr) begin
      en_q   <= wdata[11];
      dbgp_q <= wdata[10];
      if (!en_q) begin
        sel_q <= wdata[0];
        div_q <= wdata[4 +: NSEL_W];
        dir_q <= wdata[12];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      run  <= 1'b0;
    end else if (tick) begin
      s1_q <= en_q;
      run  <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run)   pre_q <= '0;
    else if (step)   pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= dir_q ? cnt_q - 1'b1 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      hi_snap <= '0;
    else if (rd_en && addr == 2'd2)  hi_snap <= cnt_q[CNT_W-1:HALF];
  end

  always_comb begin
    cfg_img = '0;
    cfg_img[0]               = sel_q;
    cfg_img[4 +: NSEL_W]     = div_q;
    cfg_img[10]              = dbgp_q;
    cfg_img[11]              = en_q;
    cfg_img[12]              = dir_q;
    case (addr)
      2'd0:    rdata = cfg_img;
      2'd1:    rdata = 32'(hi_snap);
      2'd2:    rdata = 32'(cnt_q[HALF-1:0]);
      default: rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/sleep_counter_chk.sv
module sleep_counter_chk #(
  parameter int CNT_W  = 32,
  parameter int NSEL_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic              en_q,
  input logic              sel_q,
  input logic              dir_q,
  input logic [NSEL_W-1:0] div_q,
  input logic              tick,
  input logic              run,
  input logic              hold,
  input logic [CNT_W-1:0]  cnt_q
);
  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wr_en && addr == 2'd0) |=> $stable({sel_q, dir_q, div_q}));

  // R10
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1) || cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R2
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  // R7
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(cnt_q));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));

  // R6
  sync_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(tick));
endmodule

bind sleep_counter sleep_counter_chk #(.CNT_W(CNT_W), .NSEL_W(NSEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .en_q(en_q),
  .sel_q(sel_q), .dir_q(dir_q), .div_q(div_q), .tick(tick), .run(run),
  .hold(hold), .cnt_q(cnt_q)
);

// File: tb/test_sleep_counter.sv
module test_sleep_counter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rc_tick = 1'b0, xtal_tick = 1'b0, cpu_halted = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sleep_counter i_sleep_counter (
    .clk(clk), .rst_n(rst_n), .rc_tick(rc_tick), .xtal_tick(xtal_tick),
    .cpu_halted(cpu_halted), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata)
  );

  // sel, dir, N, T, expected signed delta
  localparam int NV = 5;
  localparam int V_SEL[NV] = '{0, 0, 1, 0, 1};
  localparam int V_DIR[NV] = '{0, 0, 0, 1, 1};
  localparam int V_N[NV]   = '{0, 2, 1, 0, 3};
  localparam int V_T[NV]   = '{5, 13, 7, 4, 20};
  localparam int V_EXP[NV] = '{5, 3, 3, -4, -2};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; addr = 2'd0; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0; addr = 2'd0;
  endtask

  task automatic rd32(output logic [31:0] v);
    logic [31:0] lo, hi;
    rd(2'd2, lo);
    rd(2'd1, hi);
    v = {hi[15:0], lo[15:0]};
  endtask

  task automatic pulse(input bit src, input int n);
    for (int i = 0; i < n; i++) begin
      if (src) xtal_tick = 1'b1; else rc_tick = 1'b1;
      @(negedge clk);
      xtal_tick = 1'b0; rc_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, v); chk("R1 reset cfg", v, 32'h0000_0400);
    rd32(v);     chk("R1 reset count", v, 32'h0);
    rd(2'd3, v); chk("R1 unused address", v, 32'h0);

    wr(32'h0000_1400);
    wr(32'h0000_1C00);
    pulse(0, 2); rd32(v); chk("R6 enable not yet effective", v, 32'h0);
    pulse(0, 1); rd32(v); chk("R8 down wrap", v, 32'hFFFF_FFFF);

    wr(32'h0000_0871);
    rd(2'd0, v); chk("R5 locked fields kept", v, 32'h0000_1800);

    wr(32'h0000_1C00);
    cpu_halted = 1'b1;
    pulse(0, 3); rd32(v); chk("R7 paused", v, 32'hFFFF_FFFF);
    wr(32'h0000_1800);
    pulse(0, 1); rd32(v); chk("R7 debug-pause off counts", v, 32'hFFFF_FFFE);
    cpu_halted = 1'b0;

    wr(32'h0000_1000);
    pulse(0, 2); rd32(v); chk("R6 disable lag", v, 32'hFFFF_FFFC);
    pulse(0, 1); rd32(v); chk("R6 disabled", v, 32'hFFFF_FFFC);

    wr(32'hFFFF_F7FF);
    rd(2'd0, v); chk("R1 reserved bits zero", v, 32'h0000_14F1);

    wr(32'h0000_0000);
    wr(32'h0000_0800);
    pulse(0, 5); rd32(v); chk("R4 up count", v, 32'hFFFF_FFFF);
    rd(2'd2, v);
    pulse(0, 1);
    rd(2'd1, v); chk("R9 captured high half", v, 32'h0000_FFFF);
    rd32(v);     chk("R8 up wrap", v, 32'h0);
    wr(32'h0000_0000);
    pulse(0, 3);

    for (int k = 0; k < NV; k++) begin
      logic [31:0] cfg;
      cfg = (32'(V_DIR[k]) << 12) | (32'(V_N[k]) << 4) | 32'(V_SEL[k]);
      wr(cfg);
      wr(cfg | 32'h0800);
      pulse(V_SEL[k] != 0, 2);
      rd32(a);
      for (int t = 0; t < V_T[k]; t++) begin
        pulse(V_SEL[k] == 0, 1);
        pulse(V_SEL[k] != 0, 1);
      end
      rd32(b);
      chk("R2 R3 R4 table delta", b - a, 32'(V_EXP[k]));
      wr(cfg);
      pulse(V_SEL[k] != 0, 3);
    end

    wr(32'h0000_00F0);
    wr(32'h0000_08F0);
    pulse(0, 2);
    rd32(a);
    pulse(0, 32767); rd32(b); chk("R3 N=15 before roll", b - a, 32'h0);
    pulse(0, 1);     rd32(b); chk("R3 N=15 roll", b - a, 32'h1);
    wr(32'h0000_00F0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule